// File: doc/BRIEF.md
# HDLC Receive Statistics and Interrupt Coalescer

This block sits beside an HDLC receiver. The receiver sends one completion pulse per frame, together with the status flags for that frame. The block sorts each completed frame into a set of wrapping 16-bit statistic counters: buffer-starved discards, CRC-class errors, aborts and address mismatches. Software can preload these counters only while the receive channel is disabled.

The block also reduces interrupt load. Frames that were delivered are counted as pending, and a single interrupt is raised when either of two things happens:
- the number of pending frames reaches a programmable threshold;
- a programmable number of cycles has passed since the first pending frame arrived.

Raising the interrupt empties the pending count and stops the timer. Software acknowledges the interrupt by writing a one to the event-clear address.

Register map on the write port (`wr_addr`):

| Address | Contents |
|---|---|
| 0 | discard counter |
| 1 | CRC-class counter |
| 2 | abort counter |
| 3 | mismatch counter |
| 4 | frame threshold (low 8 bits) |
| 5 | timeout in cycles (16 bits) |
| 6 | event clear (bit 0) |
| 7 | unused |

Top module: `hdlc_rx_stats`

## Requirements
- R1: After reset, all four counters read 0 and `irq` is 0. Every counter is 16 bits wide and wraps from 0xFFFF to 0 on increment.
- R2: The discard counter increments on a completed frame that has `st_busy`=1 and none of `st_crc_err`, `st_abort` or `st_overrun`.
- R3: The CRC-class counter increments on a completed frame that has neither `st_overrun` nor `st_abort`, and has at least one of `st_crc_err`, `st_no_addr` or `st_busy`. An overrun frame never changes this counter.
- R4: The abort counter increments exactly once for each completed frame that has `st_abort`=1.
- R5: The mismatch counter increments on a completed frame that has `st_no_addr`=1 and none of `st_crc_err`, `st_abort` or `st_overrun`.
- R6: A completed frame with `frm_good`=1 adds one to the pending count. When the pending count reaches the threshold, `irq` is 1 from the next cycle. A threshold of 0 or 1 raises `irq` on every good frame.
- R7: With a non-zero timeout T, a pending count below the threshold raises `irq`. It does so in the cycle after T+1 clock edges have passed since the edge that captured the first pending frame. A timeout of 0 disables the timer.
- R8: Raising the interrupt, by threshold or by timeout, resets the pending count to zero and stops the timer.
- R9: A write to address 6 with bit 0 = 1 clears `irq`. If an interrupt is raised in the same cycle, the interrupt wins.
- R10: Writes to addresses 0-3 load the matching counter only while `chan_en`=0, and they take precedence over a same-cycle increment. While `chan_en`=1 these writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Receive channel enabled; blocks counter writes |
| frm_done | input | 1 | One-cycle frame completion pulse |
| frm_good | input | 1 | Frame delivered to a buffer (counts toward interrupt) |
| st_crc_err | input | 1 | Frame failed its CRC |
| st_abort | input | 1 | Frame ended by an abort sequence |
| st_overrun | input | 1 | Frame suffered a receive overrun |
| st_no_addr | input | 1 | Frame address did not match |
| st_busy | input | 1 | No free buffer when the frame arrived |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| cnt_discard | output | 16 | Discard counter |
| cnt_crc | output | 16 | CRC-class error counter |
| cnt_abort | output | 16 | Abort counter |
| cnt_nomatch | output | 16 | Address mismatch counter |
| irq | output | 1 | Coalesced frame-received interrupt |

## Verification
A wrong classification rule shows at the counter outputs one cycle after the offending `frm_done`. The reference model compares every counter on every clock, so the error is reported at once.

A wrong pending count or timer state does not show until the next good frame or the next timeout. At that point `irq` rises one or more cycles too early or too late. Directed sequences with a threshold of 4 and a timeout of 5 pin down the exact edge at which `irq` must rise, and randomised traffic with small thresholds and timeouts repeats those boundaries many times.

// File: rtl/hdlc_stats_pkg.sv
package hdlc_stats_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_CNT = 4;
  // register addresses; counters take 0..NUM_CNT-1 in index order
  localparam int A_DISC  = 0;
  localparam int A_CRC   = 1;
  localparam int A_ABRT  = 2;
  localparam int A_NOMAT = 3;
  localparam int A_THR   = 4;
  localparam int A_TMO   = 5;
  localparam int A_EVCLR = 6;

  // field order puts disc at bit 0 so the packed value indexes like the addresses
  typedef struct packed {
    logic nomatch;
    logic abrt;
    logic crc;
    logic disc;
  } inc_t;

  function automatic inc_t classify(input logic crc_err, input logic abrt,
                                    input logic ovr, input logic no_addr,
                                    input logic busy);
    inc_t r;
    logic clean;
    clean     = !crc_err && !abrt && !ovr;
    r.disc    = clean && busy;
    r.crc     = !ovr && !abrt && (crc_err || no_addr || busy);
    r.abrt    = abrt;
    r.nomatch = clean && no_addr;
    return r;
  endfunction
endpackage

// File: rtl/hdlc_stat_counter.sv
module hdlc_stat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] wrap_inc(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  logic [W-1:0] q_d;

  always_comb begin
    if (ld)       q_d = ld_val;
    else if (inc) q_d = wrap_inc(q);
    else          q_d = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/hdlc_evt_coalesce.sv
module hdlc_evt_coalesce #(
  parameter int THR_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_ev,
  input  logic [THR_W-1:0] thr,
  input  logic [TMR_W-1:0] tmo,
  input  logic             clr_req,
  output logic             irq,
  output logic             fire_thr,
  output logic             fire_tmo,
  output logic [THR_W-1:0] pend
);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  function automatic logic [THR_W:0] eff_thr(input logic [THR_W-1:0] t);
    return (t == '0) ? (THR_W+1)'(1) : {1'b0, t};
  endfunction

  function automatic logic [TMR_W-1:0] sat_inc(input logic [TMR_W-1:0] v);
    return (v == TMR_MAX) ? v : v + TMR_W'(1);
  endfunction

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [THR_W-1:0] pend_d;
  logic [THR_W:0]   base, nxt;
  logic             irq_d;

  always_comb begin
    fire_tmo = (pend != '0) && (tmo != '0) && (tmr_q >= tmo);
    base     = fire_tmo ? '0 : {1'b0, pend};
    nxt      = base + {{THR_W{1'b0}}, frm_ev};
    fire_thr = frm_ev && (nxt >= eff_thr(thr));
    pend_d   = fire_thr ? '0 : nxt[THR_W-1:0];
    if (pend_d == '0)     tmr_d = '0;
    else if (base == '0)  tmr_d = '0;
    else                  tmr_d = sat_inc(tmr_q);
    if (fire_thr || fire_tmo) irq_d = 1'b1;
    else if (clr_req)         irq_d = 1'b0;
    else                      irq_d = irq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      tmr_q <= '0;
      irq   <= 1'b0;
    end else begin
      pend  <= pend_d;
      tmr_q <= tmr_d;
      irq   <= irq_d;
    end
  end
endmodule

// File: rtl/hdlc_rx_stats.sv
module hdlc_rx_stats
  import hdlc_stats_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int THR_W   = 8,
  parameter int TMR_W   = 16,
  parameter int THR_RST = 1,
  parameter int TMO_RST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              frm_done,
  input  logic              frm_good,
  input  logic              st_crc_err,
  input  logic              st_abort,
  input  logic              st_overrun,
  input  logic              st_no_addr,
  input  logic              st_busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cnt_discard,
  output logic [CNT_W-1:0]  cnt_crc,
  output logic [CNT_W-1:0]  cnt_abort,
  output logic [CNT_W-1:0]  cnt_nomatch,
  output logic              irq
);
  inc_t               cls;
  logic [NUM_CNT-1:0] inc_vec, ld_vec;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic [THR_W-1:0]   thr_q, pend_cnt;
  logic [TMR_W-1:0]   tmo_q;
  logic               frm_ev, clr_req, fire_thr, fire_tmo;

  always_comb begin
    cls     = classify(st_crc_err, st_abort, st_overrun, st_no_addr, st_busy);
    inc_vec = frm_done ? NUM_CNT'(cls) : '0;
    for (int i = 0; i < NUM_CNT; i++)
      ld_vec[i] = wr_en && !chan_en && (wr_addr == ADDR_W'(i));
    frm_ev  = frm_done && frm_good;
    clr_req = wr_en && (wr_addr == ADDR_W'(A_EVCLR)) && wr_data[0];
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    hdlc_stat_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc_vec[g]),
      .ld     (ld_vec[g]),
      .ld_val (wr_data),
      .q      (cnt_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= THR_W'(THR_RST);
      tmo_q <= TMR_W'(TMO_RST);
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_THR)) thr_q <= wr_data[THR_W-1:0];
      if (wr_addr == ADDR_W'(A_TMO)) tmo_q <= wr_data[TMR_W-1:0];
    end
  end

  hdlc_evt_coalesce #(.THR_W(THR_W), .TMR_W(TMR_W)) u_coal (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_ev   (frm_ev),
    .thr      (thr_q),
    .tmo      (tmo_q),
    .clr_req  (clr_req),
    .irq      (irq),
    .fire_thr (fire_thr),
    .fire_tmo (fire_tmo),
    .pend     (pend_cnt)
  );

  assign cnt_discard = cnt_q[A_DISC];
  assign cnt_crc     = cnt_q[A_CRC];
  assign cnt_abort   = cnt_q[A_ABRT];
  assign cnt_nomatch = cnt_q[A_NOMAT];
endmodule

// File: rtl/hdlc_rx_stats_chk.sv
module hdlc_rx_stats_chk #(
  parameter int CNT_W = 16,
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic             frm_done,
  input logic             st_abort,
  input logic             st_overrun,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt_discard,
  input logic [CNT_W-1:0] cnt_crc,
  input logic [CNT_W-1:0] cnt_abort,
  input logic [CNT_W-1:0] cnt_nomatch,
  input logic             irq,
  input logic             fire_thr,
  input logic             fire_tmo,
  input logic [THR_W-1:0] pend_cnt
);
  logic cnt_wr;
  logic clr_wr;
  assign cnt_wr = wr_en && !chan_en && (wr_addr < 3'd4);
  assign clr_wr = wr_en && (wr_addr == 3'd6) && wr_data[0];

  assert_abort_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && st_abort && !cnt_wr |=> cnt_abort == $past(cnt_abort) + 1'b1);

  assert_overrun_no_crc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && st_overrun && !cnt_wr |=> $stable(cnt_crc));

  assert_locked_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && chan_en && !frm_done |=>
      $stable(cnt_discard) && $stable(cnt_crc) && $stable(cnt_abort) && $stable(cnt_nomatch));

  assert_thr_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_thr |=> irq);

  assert_tmo_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_tmo |=> irq);

  assert_pend_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_thr |=> pend_cnt == '0);

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && clr_wr && !fire_thr && !fire_tmo |=> !irq);
endmodule

bind hdlc_rx_stats hdlc_rx_stats_chk #(.CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_en     (chan_en),
  .frm_done    (frm_done),
  .st_abort    (st_abort),
  .st_overrun  (st_overrun),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .cnt_discard (cnt_discard),
  .cnt_crc     (cnt_crc),
  .cnt_abort   (cnt_abort),
  .cnt_nomatch (cnt_nomatch),
  .irq         (irq),
  .fire_thr    (fire_thr),
  .fire_tmo    (fire_tmo),
  .pend_cnt    (pend_cnt)
);

// File: tb/test_hdlc_rx_stats.sv
module test_hdlc_rx_stats;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b1;
  logic frm_done = 0, frm_good = 0, st_crc_err = 0, st_abort = 0;
  logic st_overrun = 0, st_no_addr = 0, st_busy = 0, wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_discard, cnt_crc, cnt_abort, cnt_nomatch;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_stats i_hdlc_rx_stats (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .frm_done(frm_done),
    .frm_good(frm_good), .st_crc_err(st_crc_err), .st_abort(st_abort),
    .st_overrun(st_overrun), .st_no_addr(st_no_addr), .st_busy(st_busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_discard(cnt_discard), .cnt_crc(cnt_crc), .cnt_abort(cnt_abort),
    .cnt_nomatch(cnt_nomatch), .irq(irq)
  );

  // behavioural reference: integers and an arrival-time queue
  int m_disc, m_crc, m_abrt, m_nm, m_thr, m_tmo, cyc;
  bit m_irq;
  int arrivals[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_disc = 0; m_crc = 0; m_abrt = 0; m_nm = 0;
      m_thr = 1; m_tmo = 0; m_irq = 0; cyc = 0;
      arrivals.delete();
    end else begin
      bit clean, raise;
      int need;
      clean = !st_crc_err && !st_abort && !st_overrun;
      if (frm_done) begin
        if (clean && st_busy) m_disc++;
        if (!st_overrun && !st_abort && (st_crc_err || st_no_addr || st_busy)) m_crc++;
        if (st_abort) m_abrt++;
        if (clean && st_no_addr) m_nm++;
      end
      if (wr_en && !chan_en) begin
        if (wr_addr == 0) m_disc = wr_data;
        if (wr_addr == 1) m_crc  = wr_data;
        if (wr_addr == 2) m_abrt = wr_data;
        if (wr_addr == 3) m_nm   = wr_data;
      end
      m_disc %= 65536; m_crc %= 65536; m_abrt %= 65536; m_nm %= 65536;
      raise = 0;
      if (arrivals.size() > 0 && m_tmo != 0 && (cyc - arrivals[0]) > m_tmo) begin
        raise = 1;
        arrivals.delete();
      end
      need = (m_thr == 0) ? 1 : m_thr;
      if (frm_done && frm_good) begin
        arrivals.push_back(cyc);
        if (arrivals.size() >= need) begin
          raise = 1;
          arrivals.delete();
        end
      end
      if (raise) m_irq = 1;
      else if (wr_en && wr_addr == 6 && wr_data[0]) m_irq = 0;
      if (wr_en && wr_addr == 4) m_thr = wr_data[7:0];
      if (wr_en && wr_addr == 5) m_tmo = wr_data;
      cyc++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model discard", {16'd0, cnt_discard}, m_disc);
      chk("R3 model crc", {16'd0, cnt_crc}, m_crc);
      chk("R4 model abort", {16'd0, cnt_abort}, m_abrt);
      chk("R5 model nomatch", {16'd0, cnt_nomatch}, m_nm);
      chk("R6 model irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  // one cycle of stimulus: drive now (at a falling edge), hold across one rising edge
  task automatic step(input logic fd, input logic gd, input logic ce, input logic ab,
                      input logic ov, input logic na, input logic bs,
                      input logic we, input logic [2:0] wa, input logic [15:0] wd);
    frm_done = fd; frm_good = gd; st_crc_err = ce; st_abort = ab;
    st_overrun = ov; st_no_addr = na; st_busy = bs;
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(negedge clk);
    frm_done = 0; frm_good = 0; st_crc_err = 0; st_abort = 0;
    st_overrun = 0; st_no_addr = 0; st_busy = 0; wr_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    step(0, 0, 0, 0, 0, 0, 0, 1, a, d);
  endtask

  task automatic good_frame();
    step(1, 1, 0, 0, 0, 0, 0, 0, 3'd0, 16'd0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 reset discard", {16'd0, cnt_discard}, 0);
    chk("R1 reset crc", {16'd0, cnt_crc}, 0);
    chk("R1 reset abort", {16'd0, cnt_abort}, 0);
    chk("R1 reset nomatch", {16'd0, cnt_nomatch}, 0);
    chk("R1 reset irq", {31'd0, irq}, 0);

    // classification (fd, gd, crc, abort, ovr, noaddr, busy)
    step(1, 0, 1, 0, 0, 0, 0, 0, 3'd0, 16'd0); // crc error
    step(1, 0, 1, 0, 1, 0, 0, 0, 3'd0, 16'd0); // overrun + crc: excluded
    step(1, 0, 0, 0, 0, 1, 0, 0, 3'd0, 16'd0); // unaddressed clean
    step(1, 0, 0, 0, 0, 0, 1, 0, 3'd0, 16'd0); // busy clean
    step(1, 0, 1, 0, 0, 0, 1, 0, 3'd0, 16'd0); // busy with crc error
    step(1, 0, 0, 1, 0, 0, 0, 0, 3'd0, 16'd0); // abort
    chk("R2 discard after mix", {16'd0, cnt_discard}, 1);
    chk("R3 crc after mix", {16'd0, cnt_crc}, 4);
    chk("R4 abort after mix", {16'd0, cnt_abort}, 1);
    chk("R5 nomatch after mix", {16'd0, cnt_nomatch}, 1);

    // wrap and write gating
    chan_en = 0;
    wr(3'd1, 16'hFFFF);
    step(1, 0, 1, 0, 0, 0, 0, 0, 3'd0, 16'd0);
    chk("R1 crc wraps to zero", {16'd0, cnt_crc}, 0);
    chan_en = 1;
    wr(3'd0, 16'h1234);
    chk("R10 write ignored while enabled", {16'd0, cnt_discard}, 1);
    chan_en = 0;
    step(1, 0, 0, 0, 0, 0, 1, 1, 3'd0, 16'd5);
    chk("R10 write beats increment", {16'd0, cnt_discard}, 5);
    chan_en = 1;

    // threshold
    wr(3'd4, 16'd0);
    good_frame();
    chk("R6 thr zero fires each frame", {31'd0, irq}, 1);
    wr(3'd6, 16'd1);
    chk("R9 clear", {31'd0, irq}, 0);
    wr(3'd4, 16'd3);
    good_frame();
    good_frame();
    chk("R6 below threshold", {31'd0, irq}, 0);
    good_frame();
    chk("R6 at threshold", {31'd0, irq}, 1);
    wr(3'd4, 16'd1);
    step(1, 1, 0, 0, 0, 0, 0, 1, 3'd6, 16'd1);
    chk("R9 raise wins over clear", {31'd0, irq}, 1);
    wr(3'd6, 16'd1);
    chk("R9 clear after", {31'd0, irq}, 0);

    // timeout
    wr(3'd4, 16'd4);
    wr(3'd5, 16'd5);
    good_frame();
    repeat (5) @(negedge clk);
    chk("R7 not yet timed out", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R7 timeout fires", {31'd0, irq}, 1);
    wr(3'd6, 16'd1);
    good_frame();
    good_frame();
    good_frame();
    chk("R8 pending restarted", {31'd0, irq}, 0);
    good_frame();
    chk("R8 fourth frame fires", {31'd0, irq}, 1);
    wr(3'd6, 16'd1);
    repeat (10) @(negedge clk);
    chk("R8 no stale timeout", {31'd0, irq}, 0);

    // randomised traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      logic [15:0] d;
      if ($urandom % 50 == 0) chan_en = ~chan_en;
      a = 3'($urandom % 8);
      d = (a == 3'd4) ? 16'($urandom % 6) :
          (a == 3'd5) ? 16'($urandom % 13) : 16'($urandom);
      step(($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 5) == 0,
           ($urandom % 7) == 0, ($urandom % 7) == 0, ($urandom % 4) == 0,
           ($urandom % 4) == 0, ($urandom % 6) == 0, a, d);
    end
    repeat (20) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule